// File: doc/BRIEF.md
# Static LCD Backplane and Segment Phase Generator

This block produces the drive pattern for a four-digit, seven-segment liquid-crystal display with one common electrode and 28 separate segment lines. An oscillator tick enable feeds a binary divider. The top bit of the divider is the square-wave backplane. Each segment line is the backplane exclusive-ORed with that segment's on bit. A lit segment therefore always sits in antiphase with the backplane, a dark one sits in phase, and the average voltage across every segment is zero.

Several of these blocks can share one display. When the oscillator pin is held low for long enough, the block stops driving its backplane and phases its segments against a backplane supplied from outside instead. That outside backplane may come from a neighbouring block or from a separate source. A low that lasts only a short time on the oscillator pin is filtered out, so a fast overdriving clock cannot switch the block into this follower mode. All logic runs on one fast system clock. The oscillator appears only as a one-cycle tick enable and as a level sampled through synchronisers.

Top module: `lcdbp_gen`

## Requirements
- R1: In leader mode the backplane output toggles after exactly DIVIDE/2 (default 64) oscillator ticks, so its duty cycle is 50 %. A tick seen at one clock edge affects the backplane at the following edge.
- R2: During and directly after the synchronous active-high reset, bp_out is 0, every seg_out bit is 0 and bp_oe is 1.
- R3: On every clock edge, seg_out[i] takes bp_out's new value XOR seg_on[i] as sampled at that same edge. Bit i of seg_on drives bit i of seg_out, with digit d occupying bits 7d to 7d+6. All segment lines and the backplane change on the same edge.
- R4: In leader mode bp_oe is 1, bp_out comes only from the divider, and bp_ext has no effect on any output.
- R5: If osc_lvl is low for HOLD consecutive synchronised samples (default 500), the block enters follower mode. When the low is applied before clock edge 1, bp_oe reads 1 after edge HOLD+1 and 0 after edge HOLD+2.
- R6: A low on osc_lvl shorter than HOLD cycles leaves bp_oe at 1. Raising osc_lvl again in follower mode returns bp_oe to 1 after the third clock edge.
- R7: In follower mode bp_out equals bp_ext delayed by three clock edges (two synchroniser stages and the output register), and seg_out is phased against that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| osc_lvl | input | 1 | Raw oscillator pin level; a sustained low requests follower mode |
| bp_ext | input | 1 | Shared backplane level applied from outside (asynchronous) |
| seg_on | input | 28 | Segment on vector from the digit latches, 1 = lit |
| bp_out | output | 1 | Registered backplane level |
| bp_oe | output | 1 | Backplane driver enable, 0 in follower mode |
| seg_out | output | 28 | Registered segment line levels |

## Verification
Embedded assertions check the following on every cycle: the antiphase relation between each segment line, the backplane and the previous segment-on vector; which source the backplane register takes in each mode; divider wrap and hold; and that follower mode only follows a low sample and is dropped after any high one. Only the bench scenarios can show the exact half-period count against a tick model and the precise cycle at which a sustained low switches the mode. The same applies to glitches of random length being rejected and to the three-edge latency from the outside backplane to bp_out.

// File: rtl/lcdbp_pkg.sv
package lcdbp_pkg;
   typedef enum logic {
      BP_LEADER   = 1'b0,
      BP_FOLLOWER = 1'b1
   } bp_mode_e;
endpackage

// File: rtl/lcdbp_sync.sv
module lcdbp_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lcdbp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lcdbp_divider.sv
module lcdbp_divider #(
   parameter int DIVIDE = 128
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   output logic msb
);
   localparam int DW = $clog2(DIVIDE);

   if (DIVIDE < 4 || (DIVIDE & (DIVIDE - 1)) != 0) begin : g_bad_divide
      $error("lcdbp_divider: DIVIDE must be a power of two, at least 4");
   end

   logic [DW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   assign msb = cnt[DW-1];

   p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
      (tick && (&cnt)) |=> (cnt == '0));
   p_idle_r1: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt));
endmodule

// File: rtl/lcdbp_follow_detect.sv
module lcdbp_follow_detect #(
   parameter int HOLD        = 500,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl_raw,
   output logic follow
);
   localparam int HW = $clog2(HOLD + 1);

   if (HOLD < 1) begin : g_bad_hold
      $error("lcdbp_follow_detect: HOLD must be at least 1");
   end

   logic          lvl_s;
   logic [HW-1:0] low_cnt;

   lcdbp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_lvl_sync (
      .clk (clk),
      .rst (rst),
      .d   (lvl_raw),
      .q   (lvl_s)
   );

   always_ff @(posedge clk) begin
      if (rst || lvl_s)               low_cnt <= '0;
      else if (low_cnt != HW'(HOLD))  low_cnt <= low_cnt + 1'b1;
   end

   assign follow = (low_cnt == HW'(HOLD));

   p_high_clears_r6: assert property (@(posedge clk) disable iff (rst)
      lvl_s |=> !follow);
   p_low_before_follow_r5: assert property (@(posedge clk) disable iff (rst)
      (follow && !$past(rst)) |-> !$past(lvl_s));
endmodule

// File: rtl/lcdbp_gen.sv
module lcdbp_gen
   import lcdbp_pkg::*;
#(
   parameter int DIGITS         = 4,
   parameter int SEGS_PER_DIGIT = 7,
   parameter int DIVIDE         = 128,
   parameter int HOLD           = 500,
   parameter int SYNC_STAGES    = 2,
   localparam int SEG_W         = DIGITS * SEGS_PER_DIGIT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             osc_tick,
   input  logic             osc_lvl,
   input  logic             bp_ext,
   input  logic [SEG_W-1:0] seg_on,
   output logic             bp_out,
   output logic             bp_oe,
   output logic [SEG_W-1:0] seg_out
);
   if (DIGITS < 1 || SEGS_PER_DIGIT < 1) begin : g_bad_shape
      $error("lcdbp_gen: DIGITS and SEGS_PER_DIGIT must be positive");
   end

   logic     div_msb;
   logic     ext_s;
   logic     follow;
   bp_mode_e mode;
   logic     bp_src;
   logic     bp_q;

   lcdbp_divider #(.DIVIDE(DIVIDE)) u_div (
      .clk  (clk),
      .rst  (rst),
      .tick (osc_tick),
      .msb  (div_msb)
   );

   lcdbp_follow_detect #(.HOLD(HOLD), .SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk     (clk),
      .rst     (rst),
      .lvl_raw (osc_lvl),
      .follow  (follow)
   );

   lcdbp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
      .clk (clk),
      .rst (rst),
      .d   (bp_ext),
      .q   (ext_s)
   );

   assign mode   = follow ? BP_FOLLOWER : BP_LEADER;
   assign bp_src = (mode == BP_FOLLOWER) ? ext_s : div_msb;
   assign bp_oe  = (mode == BP_LEADER);

   always_ff @(posedge clk) begin
      if (rst) bp_q <= 1'b0;
      else     bp_q <= bp_src;
   end
   assign bp_out = bp_q;

   for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      logic [SEGS_PER_DIGIT-1:0] seg_q;
      always_ff @(posedge clk) begin
         if (rst) seg_q <= '0;
         else     seg_q <= seg_on[d*SEGS_PER_DIGIT +: SEGS_PER_DIGIT]
                           ^ {SEGS_PER_DIGIT{bp_src}};
      end
      assign seg_out[d*SEGS_PER_DIGIT +: SEGS_PER_DIGIT] = seg_q;
   end

   p_seg_phase_r3: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (seg_out == ({SEG_W{bp_out}} ^ $past(seg_on))));
   p_leader_src_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !follow && !$past(follow)) |-> (bp_out == $past(div_msb)));
   p_follower_src_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && follow && $past(follow)) |-> (bp_out == $past(ext_s)));
   p_reset_state_r2: assert property (@(posedge clk)
      $past(rst) |-> (!bp_out && seg_out == '0));
endmodule

// File: tb/lcdbp_gen_tb.sv
`timescale 1ns/1ps
module lcdbp_gen_tb;
   localparam int SEG_W = 28;
   localparam int HOLD  = 500;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst = 1'b1;
   logic             osc_tick = 1'b0;
   logic             osc_lvl = 1'b1;
   logic             bp_ext = 1'b0;
   logic [SEG_W-1:0] seg_on = '0;
   logic             bp_out;
   logic             bp_oe;
   logic [SEG_W-1:0] seg_out;

   lcdbp_gen u_dut (
      .clk(clk), .rst(rst), .osc_tick(osc_tick), .osc_lvl(osc_lvl),
      .bp_ext(bp_ext), .seg_on(seg_on), .bp_out(bp_out), .bp_oe(bp_oe),
      .seg_out(seg_out)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // model of what the design saw at each rising edge
   logic             tick_seen = 1'b0;
   logic             rst_seen  = 1'b1;
   logic [SEG_W-1:0] seg_seen  = '0;
   logic [6:0]       model_cnt = '0;
   bit               chk_leader = 1'b0;

   always @(posedge clk) begin
      tick_seen <= osc_tick;
      rst_seen  <= rst;
      seg_seen  <= seg_on;
   end

   function automatic logic [SEG_W-1:0] exp_seg(input logic bp, input logic [SEG_W-1:0] on);
      return {SEG_W{bp}} ^ on;
   endfunction

   always @(negedge clk) begin
      if (!done) begin
         if (rst_seen) model_cnt = '0;
         else begin
            // R1: backplane is the top bit of the tick count before the last edge
            if (chk_leader) begin
               check(bp_out == model_cnt[6], "R1", 64'(bp_out), 64'(model_cnt[6]));
               check(bp_oe == 1'b1, "R4", 64'(bp_oe), 64'd1);
            end
            model_cnt = model_cnt + 7'(tick_seen);
            // R3: every segment phased against the backplane
            check(seg_out == exp_seg(bp_out, seg_seen), "R3",
                  64'(seg_out), 64'(exp_seg(bp_out, seg_seen)));
         end
      end
   end

   task automatic leader_random(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         osc_tick = 1'($urandom % 2);
         seg_on   = SEG_W'($urandom);
         bp_ext   = 1'($urandom % 2);   // R4: must have no effect
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      seg_on = '1;
      repeat (3) @(negedge clk);
      // R2: reset state
      check(bp_out == 1'b0, "R2", 64'(bp_out), 64'd0);
      check(seg_out == '0, "R2", 64'(seg_out), 64'd0);
      check(bp_oe == 1'b1, "R2", 64'(bp_oe), 64'd1);
      rst = 1'b0;
      chk_leader = 1'b1;

      // R1: directed run with a tick every cycle, full/empty segment patterns
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         osc_tick = 1'b1;
         seg_on   = ((i / 50) % 2 == 0) ? '1 : '0;
      end
      leader_random(2000);

      // R6: glitches shorter than HOLD, longest first
      for (int k = 0; k < 5; k++) begin
         int len;
         len = (k == 0) ? HOLD - 1 : 1 + int'($urandom % (HOLD - 1));
         @(negedge clk);
         osc_lvl = 1'b0; osc_tick = 1'b0;
         for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == len - 1) osc_lvl = 1'b1;
            check(bp_oe == 1'b1, "R6", 64'(bp_oe), 64'd1);
         end
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(bp_oe == 1'b1, "R6", 64'(bp_oe), 64'd1);
         end
         leader_random(40);
      end

      // R5: sustained low enters follower mode on the exact edge
      @(negedge clk);
      chk_leader = 1'b0;
      osc_tick = 1'b0; bp_ext = 1'b0;
      osc_lvl = 1'b0;
      repeat (HOLD + 1) @(negedge clk);
      check(bp_oe == 1'b1, "R5", 64'(bp_oe), 64'd1);
      @(negedge clk);
      check(bp_oe == 1'b0, "R5", 64'(bp_oe), 64'd0);
      repeat (4) @(negedge clk);

      // R7: backplane follows the outside level after three edges
      begin
         logic prev;
         prev = 1'b0;
         for (int k = 0; k < 16; k++) begin
            logic nv;
            nv = (k % 4 == 3) ? prev : ~prev;
            bp_ext = nv;
            seg_on = SEG_W'($urandom);
            repeat (2) @(negedge clk);
            check(bp_out == prev, "R7", 64'(bp_out), 64'(prev));
            seg_on = SEG_W'($urandom);
            @(negedge clk);
            check(bp_out == nv, "R7", 64'(bp_out), 64'(nv));
            check(bp_oe == 1'b0, "R7", 64'(bp_oe), 64'd0);
            seg_on = SEG_W'($urandom);
            prev = nv;
            repeat (3) @(negedge clk);
         end
      end

      // R6: a high returns leader mode after the third edge
      osc_lvl = 1'b1;
      repeat (2) @(negedge clk);
      check(bp_oe == 1'b0, "R6", 64'(bp_oe), 64'd0);
      @(negedge clk);
      check(bp_oe == 1'b1, "R6", 64'(bp_oe), 64'd1);
      @(negedge clk);
      chk_leader = 1'b1;
      leader_random(1000);

      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule